// File: doc/BRIEF.md
# Real-Time Counter Interrupt Flag Register

This block holds the sticky interrupt flags of a real-time counter. Four hardware events can set a flag: a counter overflow, a match on either of two comparators, and the end of a synchronization-busy period. Each flag is set on the counter clock edge that samples its event. Software reads the flag byte over a small register bus and clears any flag by writing a one to its bit. Writing a zero to a bit leaves that flag as it is.

One interrupt line is high whenever a set flag has its bit set in an externally supplied enable mask. The synchronization-ready flag is set only when the busy status falls. That falling edge is ignored when an enable operation or a software reset was signalled during the busy period. A software reset also clears every flag. Everything runs on the counter clock, with a synchronous active-high reset.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset, `flags` reads 0x00 and `irq` is low.
- R2: A high `ovf_evt` sampled at a clock edge sets flag bit 7 at that edge, so the bit is visible in the following cycle.
- R3: A high `cmp_evt[i]` sampled at a clock edge sets flag bit i (bit 0 for comparator 0, bit 1 for comparator 1) at that edge.
- R4: A bus write to address 0x08 clears each flag whose `bus_wdata` bit is one. Zero bits in the write data, and writes to any other address, leave the flags unchanged.
- R5: When a set event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R6: Flag bit 6 is set at the first edge that samples `sync_busy` low after it was sampled high.
- R7: If `en_cause` or `swrst_cause` is sampled high while `sync_busy` is high, the falling edge that ends that busy period does not set bit 6.
- R8: A high `swrst_cause` clears all flags at that edge, even when a set event is present in the same cycle.
- R9: Bits 5 down to 2 of `flags` and of `bus_rdata` always read zero. `bus_rdata` returns the flag byte when `bus_addr` is 0x08, and zero for any other address.
- R10: `irq` is high exactly when some bit is one in both `flags` and `irq_mask`.
- R11: A flag stays set after its event goes away, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt | input | 1 | Overflow condition pulse |
| cmp_evt | input | 2 | Compare-match pulses, one per comparator |
| sync_busy | input | 1 | Synchronization-busy status level |
| en_cause | input | 1 | Enable operation in progress |
| swrst_cause | input | 1 | Software reset request |
| bus_addr | input | 8 | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data |
| irq_mask | input | 8 | Interrupt enable mask, one bit per flag |
| flags | output | 8 | Current flag byte |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench writes a one to clear a compare flag in the same cycle that its event fires. A design that lets the clear win would lose that event and read the bit as zero. It also ends one busy period after an enable cause and another after none. A design with a missing or stuck qualifier would set the ready flag on the wrong period. The bench fires a software reset together with an overflow event, which exposes any design that lets the set override the wipe. It writes zeros to the flag address and ones to a different address, and a loose decoder shows up as flags cleared without a request.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int DATA_W_DEF  = 8;
    localparam int ADDR_W_DEF  = 8;
    localparam int NUM_CMP_DEF = 2;
    localparam logic [7:0] FLAG_ADDR_DEF = 8'h08;

    // Bit positions that depend only on the byte width
    function automatic int ovf_pos(int dw);
        return dw - 1;
    endfunction

    function automatic int srdy_pos(int dw);
        return dw - 2;
    endfunction

    // Which bits of the flag byte hold real storage
    function automatic logic [31:0] impl_mask(int dw, int ncmp);
        logic [31:0] m;
        m = (32'd1 << ncmp) - 32'd1;
        m = m | (32'd1 << ovf_pos(dw)) | (32'd1 << srdy_pos(dw));
        return m;
    endfunction

    typedef struct packed {
        logic busy_q;
        logic pend_q;
    } sync_state_t;

endpackage

// File: rtl/rtc_sync_detect.sv
module rtc_sync_detect
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic en_cause,
    input  logic swrst_cause,
    output logic srdy_set
);
    sync_state_t st_q, st_d;
    logic fall;

    assign fall     = st_q.busy_q & ~busy;
    assign srdy_set = fall & ~st_q.pend_q;

    always_comb begin
        st_d.busy_q = busy;
        if (fall)
            st_d.pend_q = 1'b0;
        else
            st_d.pend_q = st_q.pend_q | ((en_cause | swrst_cause) & busy);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
    parameter int          W    = 8,
    parameter logic [31:0] IMPL = 32'hC3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wipe,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_store
            logic f_q;
            always_ff @(posedge clk) begin
                if (rst || wipe)     f_q <= 1'b0;
                else if (set_vec[i]) f_q <= 1'b1;
                else if (clr_vec[i]) f_q <= 1'b0;
            end
            assign flags[i] = f_q;
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port #(
    parameter int             AW   = 8,
    parameter int             DW   = 8,
    parameter logic [AW-1:0]  ADDR = 8'h08
) (
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] flags,
    output logic [DW-1:0] clr_vec,
    output logic [DW-1:0] bus_rdata
);
    logic hit;
    assign hit       = (bus_addr == ADDR);
    assign clr_vec   = (hit && bus_we) ? bus_wdata : '0;
    assign bus_rdata = hit ? flags : '0;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int                  DATA_W    = DATA_W_DEF,
    parameter int                  ADDR_W    = ADDR_W_DEF,
    parameter int                  NUM_CMP   = NUM_CMP_DEF,
    parameter logic [ADDR_W-1:0]   FLAG_ADDR = FLAG_ADDR_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ovf_evt,
    input  logic [NUM_CMP-1:0] cmp_evt,
    input  logic               sync_busy,
    input  logic               en_cause,
    input  logic               swrst_cause,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  irq_mask,
    output logic [DATA_W-1:0]  flags,
    output logic               irq
);
    localparam int          OVF_B  = ovf_pos(DATA_W);
    localparam int          SRDY_B = srdy_pos(DATA_W);
    localparam logic [31:0] IMPL   = impl_mask(DATA_W, NUM_CMP);

    logic              srdy_set;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    rtc_sync_detect u_sync (
        .clk        (clk),
        .rst        (rst),
        .busy       (sync_busy),
        .en_cause   (en_cause),
        .swrst_cause(swrst_cause),
        .srdy_set   (srdy_set)
    );

    always_comb begin
        set_vec                = '0;
        set_vec[OVF_B]         = ovf_evt;
        set_vec[SRDY_B]        = srdy_set;
        set_vec[NUM_CMP-1:0]   = cmp_evt;
    end

    rtc_bus_port #(.AW(ADDR_W), .DW(DATA_W), .ADDR(FLAG_ADDR)) u_bus (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .flags    (flags),
        .clr_vec  (clr_vec),
        .bus_rdata(bus_rdata)
    );

    rtc_flag_bank #(.W(DATA_W), .IMPL(IMPL)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wipe   (swrst_cause),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .flags  (flags)
    );

    assign irq = |(flags & irq_mask);
endmodule

// File: rtl/rtc_irq_flags_chk.sv
module rtc_irq_flags_chk #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter int                NUM_CMP   = 2,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h08
) (
    input logic               clk,
    input logic               rst,
    input logic               ovf_evt,
    input logic [NUM_CMP-1:0] cmp_evt,
    input logic               swrst_cause,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  flags
);
    logic wr_hit;
    assign wr_hit = bus_we && (bus_addr == FLAG_ADDR);

    p_ovf_set_r2: assert property (@(posedge clk) disable iff (rst)
        ovf_evt && !swrst_cause |=> flags[DATA_W-1]);

    p_cmp0_set_r3: assert property (@(posedge clk) disable iff (rst)
        cmp_evt[0] && !swrst_cause |=> flags[0]);

    p_cmp1_set_r3: assert property (@(posedge clk) disable iff (rst)
        cmp_evt[1] && !swrst_cause |=> flags[1]);

    p_ovf_clear_r4: assert property (@(posedge clk) disable iff (rst)
        wr_hit && bus_wdata[DATA_W-1] && !ovf_evt |=> !flags[DATA_W-1]);

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        flags[DATA_W-1] && !swrst_cause && !(wr_hit && bus_wdata[DATA_W-1])
        |=> flags[DATA_W-1]);

    p_cmp0_win_r5: assert property (@(posedge clk) disable iff (rst)
        cmp_evt[0] && wr_hit && bus_wdata[0] && !swrst_cause |=> flags[0]);

    p_wipe_r8: assert property (@(posedge clk) disable iff (rst)
        swrst_cause |=> (flags == '0));

    p_unimpl_r9: assert property (@(posedge clk) disable iff (rst)
        flags[DATA_W-3:NUM_CMP] == '0);
endmodule

bind rtc_irq_flags rtc_irq_flags_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ovf_evt    (ovf_evt),
    .cmp_evt    (cmp_evt),
    .swrst_cause(swrst_cause),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .flags      (flags)
);

// File: tb/rtc_irq_flags_test.sv
`timescale 1ns/1ps
module rtc_irq_flags_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovf_evt = 1'b0;
    logic [1:0] cmp_evt = 2'b00;
    logic       sync_busy = 1'b0;
    logic       en_cause = 1'b0;
    logic       swrst_cause = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_mask = 8'h00;
    logic [7:0] flags;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] flags;
        logic       irq;
        logic [7:0] rdata;
        string      tag;
    } exp_t;
    exp_t q[$];

    // reference state, built from the requirements
    logic [7:0] m_flags = 8'h00;
    logic       m_busy  = 1'b0;
    logic       m_pend  = 1'b0;

    always #2 clk = ~clk;

    rtc_irq_flags uut (
        .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
        .sync_busy(sync_busy), .en_cause(en_cause), .swrst_cause(swrst_cause),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_mask(irq_mask), .flags(flags), .irq(irq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic ov, input logic [1:0] cm, input logic bz,
                        input logic en, input logic sw, input logic we,
                        input logic [7:0] ad, input logic [7:0] wd,
                        input logic [7:0] mk, input string tag);
        logic [7:0] setv, clrv;
        logic       fall;
        exp_t       e;
        @(negedge clk);
        ovf_evt = ov; cmp_evt = cm; sync_busy = bz; en_cause = en;
        swrst_cause = sw; bus_we = we; bus_addr = ad; bus_wdata = wd;
        irq_mask = mk;
        @(posedge clk);
        fall = m_busy && !bz;
        setv = {ov, fall && !m_pend, 4'b0000, cm};
        clrv = (we && ad == 8'h08) ? wd : 8'h00;
        if (sw) m_flags = 8'h00;
        else    m_flags = ((m_flags & ~clrv) | setv) & 8'hC3;
        m_pend = fall ? 1'b0 : (m_pend || ((en || sw) && bz));
        m_busy = bz;
        e.flags = m_flags;
        e.irq   = |(m_flags & mk);
        e.rdata = (ad == 8'h08) ? m_flags : 8'h00;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic idle(input logic [7:0] mk, input string tag);
        step(0, 2'b00, 0, 0, 0, 0, 8'h08, 8'h00, mk, tag);
    endtask

    // monitor: compares outputs just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(flags == e.flags, {e.tag, " flags"}, flags, e.flags);
                check(irq == e.irq, {e.tag, " irq"}, {7'd0, irq}, {7'd0, e.irq});
                check(bus_rdata == e.rdata, {e.tag, " rdata"}, bus_rdata, e.rdata);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(flags == 8'h00, "R1 flags", flags, 8'h00);
        check(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
        // R2 overflow, R11 sticky
        step(1, 2'b00, 0, 0, 0, 0, 8'h08, 8'h00, 8'h00, "R2 ovf set");
        idle(8'h00, "R11 ovf holds");
        // R3 compare flags
        step(0, 2'b01, 0, 0, 0, 0, 8'h08, 8'h00, 8'h00, "R3 cmp0");
        step(0, 2'b10, 0, 0, 0, 0, 8'h08, 8'h00, 8'h00, "R3 cmp1");
        // R10 interrupt masking
        idle(8'h00, "R10 mask none");
        idle(8'h80, "R10 mask ovf");
        idle(8'h40, "R10 mask srdy only");
        // R4 clear rules
        step(0, 2'b00, 0, 0, 0, 1, 8'h08, 8'h00, 8'hFF, "R4 write zero");
        step(0, 2'b00, 0, 0, 0, 1, 8'h04, 8'hFF, 8'hFF, "R4 other addr");
        step(0, 2'b00, 0, 0, 0, 1, 8'h08, 8'h80, 8'hFF, "R4 clear ovf");
        idle(8'h01, "R11 cmp0 remains");
        // R5 set beats clear
        step(0, 2'b01, 0, 0, 0, 1, 8'h08, 8'h03, 8'h03, "R5 set wins");
        // R9 read of other address
        idle(8'h00, "R9 read");
        step(0, 2'b00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h00, "R9 other addr reads zero");
        // R6 busy falling edge
        step(0, 2'b00, 1, 0, 0, 0, 8'h08, 8'h00, 8'h40, "R6 busy high");
        step(0, 2'b00, 1, 0, 0, 0, 8'h08, 8'h00, 8'h40, "R6 busy held");
        step(0, 2'b00, 0, 0, 0, 0, 8'h08, 8'h00, 8'h40, "R6 srdy set");
        step(0, 2'b00, 0, 0, 0, 1, 8'h08, 8'h40, 8'h40, "R4 clear srdy");
        // R7 enable-caused busy period
        step(0, 2'b00, 1, 1, 0, 0, 8'h08, 8'h00, 8'h40, "R7 enable busy");
        step(0, 2'b00, 1, 0, 0, 0, 8'h08, 8'h00, 8'h40, "R7 busy held");
        step(0, 2'b00, 0, 0, 0, 0, 8'h08, 8'h00, 8'h40, "R7 no srdy");
        idle(8'h40, "R7 still no srdy");
        // R7 qualifier releases for next plain period
        step(0, 2'b00, 1, 0, 0, 0, 8'h08, 8'h00, 8'h40, "R6 plain busy");
        step(0, 2'b00, 0, 0, 0, 0, 8'h08, 8'h00, 8'h40, "R6 srdy again");
        // R9 all implemented bits set
        step(1, 2'b11, 0, 0, 0, 0, 8'h08, 8'h00, 8'hFF, "R9 all flags");
        // R8 software reset beats set, and R7 for its busy end
        step(0, 2'b00, 1, 0, 0, 0, 8'h08, 8'h00, 8'hFF, "R8 pre busy");
        step(1, 2'b11, 1, 0, 1, 0, 8'h08, 8'h00, 8'hFF, "R8 wipe");
        step(0, 2'b00, 0, 0, 0, 0, 8'h08, 8'h00, 8'hFF, "R7 swrst no srdy");
        idle(8'hFF, "R8 stays clear");
        @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule